// File: doc/BRIEF.md
# Sixteen-bit execute-stage ALU with zero and negative flags

This unit is the arithmetic and logic step of a 16-bit processor that has sixteen general registers and fixed four-byte instructions. Upstream decode logic presents one instruction per issue strobe. Each instruction arrives as four fields: the 8-bit operation code, the index of the primary register X, the values read from registers X and Y, and the 16-bit immediate (high byte HH, low byte LL). The low four bits of the immediate also serve two other roles: they name a third register Z, and they give a shift count.

One clock edge after an accepted issue, the unit presents a registered result, the index of the destination register and a one-cycle write strobe. It also keeps two persistent condition bits. The zero bit is set when the result is 0. The negative bit copies the result's sign bit. Both bits are updated by every operation the unit recognises, including the test-only AND, which writes no register. Operation codes the unit does not recognise leave the condition bits alone and produce no write.

Top module: `alu16_exec`

## Requirements
- R1: While reset is held, and after it is released, `res_data`, `dst_sel`, `wr_en`, `flag_zero` and `flag_neg` are all 0.
- R2: Code 0xE0 writes the bitwise complement of `imm_val` into register X (`dst_sel` = `x_sel`). Code 0xE2 writes the complement of `ry_data` into register X.
- R3: Code 0xE3 writes the two's-complement negation of `imm_val` into register X. For example, an immediate of 2 gives 0xFFFE.
- R4: On every recognised operation, `flag_zero` becomes 1 exactly when the 16-bit result is 0, and `flag_neg` becomes bit 15 of the result.
- R5: Code 0x60 writes `rx_data & imm_val` into register X. Code 0x62 writes `rx_data & ry_data` into register Z, where Z is `imm_val[3:0]`.
- R6: Code 0x63 forms `rx_data & imm_val` and updates both flags from it, but keeps `wr_en` at 0.
- R7: Code 0x40 writes `rx_data + imm_val` into register X, and code 0x51 writes `rx_data - ry_data` into register X. Both results are truncated to 16 bits.
- R8: Code 0xA3 writes `rx_data` modulo `imm_val` into register X. When the immediate is 0, it writes 0 and sets the zero flag, without stalling.
- R9: Code 0xB1 writes `rx_data` logically shifted right by `imm_val[3:0]` bit positions into register X.
- R10: An unrecognised code, or a cycle with `issue_valid` low, leaves `wr_en` at 0 and both flags unchanged.
- R11: Results, destination and write strobe appear on the rising edge that follows the issue, and `wr_en` is a single-cycle pulse for each writing issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 8 | Operation code byte |
| x_sel | input | 4 | Index of register X |
| imm_val | input | 16 | Immediate HH:LL; the low nibble also gives Z and the shift count |
| rx_data | input | 16 | Value of register X |
| ry_data | input | 16 | Value of register Y |
| res_data | output | 16 | Registered result |
| dst_sel | output | 4 | Destination register index |
| wr_en | output | 1 | Register write strobe, one cycle |
| flag_zero | output | 1 | Zero condition bit |
| flag_neg | output | 1 | Negative condition bit |

## Verification
The bench checks that the AND into Z steers the destination from the immediate's low nibble; a design that used X there would overwrite the wrong register. It checks that the test-only AND moves the flags while keeping the write strobe low, and that an unknown code or an idle cycle leaves earlier flag values in place. It also covers modulo by zero (a careless divider yields an undefined value instead of 0 with the zero bit set), additions that wrap past 0xFFFF, and shift counts of 0 and 15. Complements and negations are run both to 0 and to values with the sign bit set, so that a design with swapped or stale flags would show it.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned REG_AW = 4;

  localparam logic [7:0] OPC_NOT_IMM  = 8'hE0;
  localparam logic [7:0] OPC_NOT_REG  = 8'hE2;
  localparam logic [7:0] OPC_NEG_IMM  = 8'hE3;
  localparam logic [7:0] OPC_AND_IMM  = 8'h60;
  localparam logic [7:0] OPC_AND_3OP  = 8'h62;
  localparam logic [7:0] OPC_TST_IMM  = 8'h63;
  localparam logic [7:0] OPC_ADD_IMM  = 8'h40;
  localparam logic [7:0] OPC_SUB_REG  = 8'h51;
  localparam logic [7:0] OPC_MOD_IMM  = 8'hA3;
  localparam logic [7:0] OPC_SHR_IMM  = 8'hB1;

  typedef enum logic [3:0] {
    FN_NONE,
    FN_NOT_IMM,
    FN_NOT_REG,
    FN_NEG_IMM,
    FN_AND_IMM,
    FN_AND_REG,
    FN_ADD_IMM,
    FN_SUB_REG,
    FN_MOD_IMM,
    FN_SHR_IMM
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    known;
    logic    writes;
    logic    dst_from_imm;
  } dec_ctl_t;

endpackage

// File: rtl/alu16_rst_sync.sv
module alu16_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  logic [7:0] op_code,
  output dec_ctl_t   ctl
);

  always_comb begin
    ctl.fn           = FN_NONE;
    ctl.known        = 1'b1;
    ctl.writes       = 1'b1;
    ctl.dst_from_imm = 1'b0;
    case (op_code)
      OPC_NOT_IMM: ctl.fn = FN_NOT_IMM;
      OPC_NOT_REG: ctl.fn = FN_NOT_REG;
      OPC_NEG_IMM: ctl.fn = FN_NEG_IMM;
      OPC_AND_IMM: ctl.fn = FN_AND_IMM;
      OPC_AND_3OP: begin
        ctl.fn           = FN_AND_REG;
        ctl.dst_from_imm = 1'b1;
      end
      OPC_TST_IMM: begin
        ctl.fn     = FN_AND_IMM;
        ctl.writes = 1'b0;
      end
      OPC_ADD_IMM: ctl.fn = FN_ADD_IMM;
      OPC_SUB_REG: ctl.fn = FN_SUB_REG;
      OPC_MOD_IMM: ctl.fn = FN_MOD_IMM;
      OPC_SHR_IMM: ctl.fn = FN_SHR_IMM;
      default: begin
        ctl.known  = 1'b0;
        ctl.writes = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  alu_fn_e        fn,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [W-1:0]   imm,
  output logic [W-1:0]   result
);

  localparam int unsigned SHW = $clog2(W);

  logic [W-1:0] stage [SHW+1];
  logic [W-1:0] mod_res;

  assign stage[0] = opa;

  generate
    for (genvar s = 0; s < SHW; s++) begin : g_shr
      assign stage[s+1] = imm[s] ? (stage[s] >> (1 << s)) : stage[s];
    end
  endgenerate

  assign mod_res = (imm == '0) ? '0 : (opa % imm);

  always_comb begin
    case (fn)
      FN_NOT_IMM: result = ~imm;
      FN_NOT_REG: result = ~opb;
      FN_NEG_IMM: result = (~imm) + W'(1);
      FN_AND_IMM: result = opa & imm;
      FN_AND_REG: result = opa & opb;
      FN_ADD_IMM: result = opa + imm;
      FN_SUB_REG: result = opa - opb;
      FN_MOD_IMM: result = mod_res;
      FN_SHR_IMM: result = stage[SHW];
      default:    result = '0;
    endcase
  end

  always_comb begin
    if (fn == FN_MOD_IMM && imm == '0) begin
      assert (result == '0) else $error("AST_MOD_ZERO_DIVISOR"); // R8
    end
  end

endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
  import alu16_pkg::*;
#(
  parameter int unsigned W    = DATA_W,
  parameter int unsigned AW   = REG_AW,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [7:0]    op_code,
  input  logic [AW-1:0] x_sel,
  input  logic [W-1:0]  imm_val,
  input  logic [W-1:0]  rx_data,
  input  logic [W-1:0]  ry_data,
  output logic [W-1:0]  res_data,
  output logic [AW-1:0] dst_sel,
  output logic          wr_en,
  output logic          flag_zero,
  output logic          flag_neg
);

  logic          arst_n;
  dec_ctl_t      ctl;
  logic [W-1:0]  alu_res;

  logic          load_en;
  logic [W-1:0]  res_d,  res_q;
  logic [AW-1:0] dst_d,  dst_q;
  logic          we_d,   we_q;
  logic          fz_d,   fz_q;
  logic          fn_d,   fn_q;

  alu16_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (arst_n)
  );

  alu16_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  alu16_core #(.W(W)) u_core (
    .fn     (ctl.fn),
    .opa    (rx_data),
    .opb    (ry_data),
    .imm    (imm_val),
    .result (alu_res)
  );

  // next-state
  assign load_en = issue_valid & ctl.known;

  always_comb begin
    res_d = res_q;
    dst_d = dst_q;
    fz_d  = fz_q;
    fn_d  = fn_q;
    we_d  = load_en & ctl.writes;
    if (load_en) begin
      res_d = alu_res;
      dst_d = ctl.dst_from_imm ? imm_val[AW-1:0] : x_sel;
      fz_d  = (alu_res == '0);
      fn_d  = alu_res[W-1];
    end
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      res_q <= '0;
      dst_q <= '0;
      fz_q  <= 1'b0;
      fn_q  <= 1'b0;
    end else if (load_en) begin
      res_q <= res_d;
      dst_q <= dst_d;
      fz_q  <= fz_d;
      fn_q  <= fn_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      we_q <= 1'b0;
    end else begin
      we_q <= we_d;
    end
  end

  assign res_data  = res_q;
  assign dst_sel   = dst_q;
  assign wr_en     = we_q;
  assign flag_zero = fz_q;
  assign flag_neg  = fn_q;

  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!arst_n)
    wr_en |-> (flag_zero == (res_data == '0))); // R4
  AST_NEG_TRACKS_SIGN: assert property (@(posedge clk) disable iff (!arst_n)
    wr_en |-> (flag_neg == res_data[W-1])); // R4
  AST_UNKNOWN_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!arst_n)
    (!issue_valid || !ctl.known) |=> ($stable(flag_zero) && $stable(flag_neg) && !wr_en)); // R10
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!arst_n)
    (issue_valid && op_code == OPC_TST_IMM) |=> !wr_en); // R6
  AST_AND3_DEST_Z: assert property (@(posedge clk) disable iff (!arst_n)
    (issue_valid && op_code == OPC_AND_3OP) |=> (wr_en && dst_sel == $past(imm_val[AW-1:0]))); // R5
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && !$past(issue_valid)) |-> 1'b0); // R11

endmodule

// File: tb/sim_alu16_exec.sv
module sim_alu16_exec;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        issue_valid;
  logic [7:0]  op_code;
  logic [3:0]  x_sel;
  logic [15:0] imm_val;
  logic [15:0] rx_data;
  logic [15:0] ry_data;
  logic [15:0] res_data;
  logic [3:0]  dst_sel;
  logic        wr_en;
  logic        flag_zero;
  logic        flag_neg;

  int checks = 0;
  int errors = 0;

  alu16_exec u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_code(op_code),
    .x_sel(x_sel), .imm_val(imm_val), .rx_data(rx_data), .ry_data(ry_data),
    .res_data(res_data), .dst_sel(dst_sel), .wr_en(wr_en),
    .flag_zero(flag_zero), .flag_neg(flag_neg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one instruction after a falling edge, sample at the next falling edge
  task automatic issue(input logic [7:0] op, input logic [3:0] x, input logic [15:0] imm,
                       input logic [15:0] rx, input logic [15:0] ry);
    op_code = op; x_sel = x; imm_val = imm; rx_data = rx; ry_data = ry;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic expect_write(input string tag, input logic [15:0] res, input logic [3:0] dst,
                              input logic z, input logic n);
    chk({tag, " wr_en"}, 16'(wr_en), 16'd1);
    chk({tag, " result"}, res_data, res);
    chk({tag, " dst"}, 16'(dst_sel), 16'(dst));
    chk({tag, " zero"}, 16'(flag_zero), 16'(z));
    chk({tag, " neg"}, 16'(flag_neg), 16'(n));
  endtask

  task automatic t_reset;
    chk("R1 res", res_data, 16'h0);
    chk("R1 dst", 16'(dst_sel), 16'h0);
    chk("R1 wr_en", 16'(wr_en), 16'h0);
    chk("R1 zero", 16'(flag_zero), 16'h0);
    chk("R1 neg", 16'(flag_neg), 16'h0);
  endtask

  task automatic t_not;
    issue(8'hE0, 4'd1, 16'h33CC, 16'hFACA, 16'h0);
    expect_write("R2 not-imm", 16'hCC33, 4'd1, 1'b0, 1'b1);
    issue(8'hE0, 4'd1, 16'hFFFF, 16'hFACA, 16'h0);
    expect_write("R2 R4 not-imm to zero", 16'h0000, 4'd1, 1'b1, 1'b0);
    issue(8'hE2, 4'd3, 16'h0, 16'h1234, 16'h33CC);
    expect_write("R2 not-reg", 16'hCC33, 4'd3, 1'b0, 1'b1);
    issue(8'hE2, 4'd3, 16'h0, 16'h1234, 16'hFFFF);
    expect_write("R2 not-reg to zero", 16'h0000, 4'd3, 1'b1, 1'b0);
  endtask

  task automatic t_neg;
    issue(8'hE3, 4'd3, 16'h0002, 16'h0, 16'h0);
    expect_write("R3 neg 2", 16'hFFFE, 4'd3, 1'b0, 1'b1);
    issue(8'hE3, 4'd5, 16'h0000, 16'h0, 16'h0);
    expect_write("R3 neg 0", 16'h0000, 4'd5, 1'b1, 1'b0);
  endtask

  task automatic t_and;
    issue(8'h60, 4'd1, 16'h0002, 16'h0007, 16'h0);
    expect_write("R5 and-imm", 16'h0002, 4'd1, 1'b0, 1'b0);
    issue(8'h62, 4'd1, 16'h0003, 16'h0007, 16'h0005);
    expect_write("R5 and-3op", 16'h0005, 4'd3, 1'b0, 1'b0);
    issue(8'h62, 4'd2, 16'h12AB, 16'hF0F0, 16'hFF00);
    expect_write("R5 and-3op z=B", 16'hF000, 4'hB, 1'b0, 1'b1);
  endtask

  task automatic t_test;
    issue(8'h63, 4'd1, 16'h0000, 16'h0007, 16'h0);
    chk("R6 test wr_en", 16'(wr_en), 16'd0);
    chk("R6 test zero", 16'(flag_zero), 16'd1);
    chk("R6 test neg", 16'(flag_neg), 16'd0);
    issue(8'h63, 4'd1, 16'h8000, 16'hFFFF, 16'h0);
    chk("R6 test wr_en 2", 16'(wr_en), 16'd0);
    chk("R6 test zero 2", 16'(flag_zero), 16'd0);
    chk("R6 test neg 2", 16'(flag_neg), 16'd1);
  endtask

  task automatic t_addsub;
    issue(8'h40, 4'd1, 16'h0003, 16'h0003, 16'h0);
    expect_write("R7 add", 16'h0006, 4'd1, 1'b0, 1'b0);
    issue(8'h40, 4'd4, 16'h0002, 16'hFFFF, 16'h0);
    expect_write("R7 add wrap", 16'h0001, 4'd4, 1'b0, 1'b0);
    issue(8'h51, 4'd1, 16'h0001, 16'h0002, 16'h0002);
    expect_write("R7 sub zero", 16'h0000, 4'd1, 1'b1, 1'b0);
    issue(8'h51, 4'd6, 16'h0000, 16'h0001, 16'h0002);
    expect_write("R7 sub wrap", 16'hFFFF, 4'd6, 1'b0, 1'b1);
  endtask

  task automatic t_mod;
    issue(8'hA3, 4'd1, 16'h0003, 16'h0004, 16'h0);
    expect_write("R8 mod", 16'h0001, 4'd1, 1'b0, 1'b0);
    issue(8'hA3, 4'd7, 16'h0000, 16'h1234, 16'h0);
    expect_write("R8 mod by zero", 16'h0000, 4'd7, 1'b1, 1'b0);
    issue(8'hA3, 4'd7, 16'h0010, 16'hFFFF, 16'h0);
    expect_write("R8 mod big", 16'h000F, 4'd7, 1'b0, 1'b0);
  endtask

  task automatic t_shr;
    issue(8'hB1, 4'd1, 16'h0003, 16'h0010, 16'h0);
    expect_write("R9 shr 3", 16'h0002, 4'd1, 1'b0, 1'b0);
    issue(8'hB1, 4'd2, 16'h00FF, 16'h8000, 16'h0);
    expect_write("R9 shr 15", 16'h0001, 4'd2, 1'b0, 1'b0);
    issue(8'hB1, 4'd2, 16'h0010, 16'h8001, 16'h0);
    expect_write("R9 shr 0", 16'h8001, 4'd2, 1'b0, 1'b1);
  endtask

  task automatic t_ignore;
    issue(8'hE3, 4'd3, 16'h0002, 16'h0, 16'h0);
    expect_write("R10 setup", 16'hFFFE, 4'd3, 1'b0, 1'b1);
    issue(8'h55, 4'd1, 16'hFFFF, 16'h0, 16'h0);
    chk("R10 unknown wr_en", 16'(wr_en), 16'd0);
    chk("R10 unknown zero", 16'(flag_zero), 16'd0);
    chk("R10 unknown neg", 16'(flag_neg), 16'd1);
    op_code = 8'h40; x_sel = 4'd2; imm_val = 16'h0000; rx_data = 16'h0; ry_data = 16'h0;
    issue_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle wr_en", 16'(wr_en), 16'd0);
    chk("R10 idle zero", 16'(flag_zero), 16'd0);
    chk("R10 idle neg", 16'(flag_neg), 16'd1);
  endtask

  task automatic t_pulse;
    issue(8'h40, 4'd9, 16'h0001, 16'h0001, 16'h0);
    chk("R11 strobe high", 16'(wr_en), 16'd1);
    chk("R11 result", res_data, 16'h0002);
    @(negedge clk);
    chk("R11 strobe drops", 16'(wr_en), 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; op_code = 8'h0; x_sel = 4'h0;
    imm_val = 16'h0; rx_data = 16'h0; ry_data = 16'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_not;
    t_neg;
    t_and;
    t_test;
    t_addsub;
    t_mod;
    t_shr;
    t_ignore;
    t_pulse;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule